// File: doc/BRIEF.md
# Transfer Status and Error Flag Unit

This unit sits beside the FIFOs and the serial shifter of a serial-bus controller. It follows a transfer's progress and reports it in three flag words: an operational word, a FIFO error word and a serial-clock error word. It also drives a level interrupt. The FIFO datapath reports push, pop, full and empty events for the input FIFO and the output FIFO, together with each FIFO's fill level. A `run` level marks the period in which the transfer is active.

Each direction can work in FIFO mode or in block mode. The mode picks which programmed word count limits that direction. The unit counts words taken into the input FIFO and words drained from the output FIFO. When a count reaches its limit, the unit raises the matching done flag. Service requests tell the host when input data is waiting and when there is room for more output data. Misuse of either FIFO and clock faults reported by the shifter are latched as errors.

All sticky flags are cleared by writing a one to their bit position. The interrupt is asserted while any done or service flag is set, or while any error is set whose enable bit is on.

Top module: `xfer_status_unit`

## Requirements
- R1: After synchronous reset, `op_flags`, `err_flags` and `serr_flags` are all zero and `irq` is low.
- R2: The live status bits of `op_flags` follow the datapath in the same cycle: bit 7 is `in_full`, bit 6 is `out_full`, bit 5 is not `in_empty`, bit 4 is not `out_empty`. Bits 3:0 read zero. Writing ones to bits 7:4 through the operational clear port has no effect.
- R3: The input limit is `rd_cnt` when `in_mode` is 0 (FIFO mode) and `in_cnt` for any other value (block mode). The output limit is `wr_cnt` when `out_mode` is 0 and `out_cnt` otherwise. While `run` is high, each `in_push` into a non-full input FIFO counts one input word. Each `out_pop` from a non-empty output FIFO counts one output word. The push or pop that brings a count to its nonzero limit sets bit 11 (input done) or bit 10 (output done) at the next edge. A limit of zero never sets its done flag. Both counts restart from zero while `run` is low.
- R4: Input service, bit 9, is set at an edge where `run` is high and one of these holds: in FIFO mode, the input FIFO is not empty; in block mode, `in_level` is at least `BLOCK_WORDS`.
- R5: Output service, bit 8, is set at an edge where `run` is high and one of these holds: in FIFO mode, `out_full` is low; in block mode, `FIFO_DEPTH - out_level` is at least `BLOCK_WORDS`.
- R6: `err_flags` records four errors. Bit 2 is set by a push into a full input FIFO. Bit 4 is set by a pop from an empty input FIFO. Bit 5 is set by a push into a full output FIFO. Bit 3 is set by a pop from an empty output FIFO while `run` is high. Bits 1:0 read zero.
- R7: `serr_flags` bit 1 is set by a pulse on `sclk_ovr_evt` and bit 0 by a pulse on `sclk_und_evt`.
- R8: A clear write with the matching write enable clears exactly the sticky bits written as one and leaves the other bits unchanged. If a bit is set and cleared in the same cycle, it ends up set.
- R9: `irq` is the OR of three terms: any of `op_flags[11:8]`, `err_flags & err_en`, and `serr_flags & serr_en`. An error whose enable is off is still recorded but does not raise `irq`. `irq` stays high until every contributing bit has been cleared.
- R10: A pop from an empty output FIFO while `run` is low does not set any error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Transfer active level |
| in_mode | input | 2 | Input direction mode, 0 = FIFO, otherwise block |
| out_mode | input | 2 | Output direction mode, 0 = FIFO, otherwise block |
| rd_cnt | input | CNT_W | Input word limit in FIFO mode |
| wr_cnt | input | CNT_W | Output word limit in FIFO mode |
| in_cnt | input | CNT_W | Input word limit in block mode |
| out_cnt | input | CNT_W | Output word limit in block mode |
| in_push | input | 1 | Word written into the input FIFO |
| in_pop | input | 1 | Word read from the input FIFO |
| in_full | input | 1 | Input FIFO full |
| in_empty | input | 1 | Input FIFO empty |
| in_level | input | LVL_W | Input FIFO occupancy in words |
| out_push | input | 1 | Word written into the output FIFO |
| out_pop | input | 1 | Word read from the output FIFO |
| out_full | input | 1 | Output FIFO full |
| out_empty | input | 1 | Output FIFO empty |
| out_level | input | LVL_W | Output FIFO occupancy in words |
| sclk_ovr_evt | input | 1 | Serial clock overrun event |
| sclk_und_evt | input | 1 | Serial clock underrun event |
| err_en | input | 6 | Interrupt enables, same positions as `err_flags` |
| serr_en | input | 2 | Interrupt enables, same positions as `serr_flags` |
| op_clr_we | input | 1 | Clear strobe for `op_flags` |
| op_clr | input | 12 | Write-1-to-clear mask for `op_flags` |
| err_clr_we | input | 1 | Clear strobe for `err_flags` |
| err_clr | input | 6 | Write-1-to-clear mask for `err_flags` |
| serr_clr_we | input | 1 | Clear strobe for `serr_flags` |
| serr_clr | input | 2 | Write-1-to-clear mask for `serr_flags` |
| op_flags | output | 12 | Operational flags |
| err_flags | output | 6 | FIFO error flags |
| serr_flags | output | 2 | Serial clock error flags |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with `FIFO_DEPTH = 8`, `BLOCK_WORDS = 4` and `CNT_W = 8`. With these values, the block-mode service thresholds sit only a few words from empty and from full. A level of 3 versus 4, or a room of 3 versus 4, steps across the threshold exactly. The small limits, 1, 2 and 3 words, let the bench reach each done flag at a known edge and compare the word before the limit with the word that meets it. A zero limit shows that the done flag stays clear.

// File: rtl/xfer_status_pkg.sv
package xfer_status_pkg;

    typedef enum logic [1:0] {
        DIR_MODE_FIFO  = 2'd0,
        DIR_MODE_BLOCK = 2'd1
    } dir_mode_e;

    // operational word bit positions
    localparam int OP_IN_DONE   = 11;
    localparam int OP_OUT_DONE  = 10;
    localparam int OP_IN_SRV    = 9;
    localparam int OP_OUT_SRV   = 8;
    localparam int OP_W         = 12;

    // error word bit positions
    localparam int ERR_OUT_OVR  = 5;
    localparam int ERR_IN_UND   = 4;
    localparam int ERR_OUT_UND  = 3;
    localparam int ERR_IN_OVR   = 2;
    localparam int ERR_W        = 6;

    // serial clock error word bit positions
    localparam int SERR_OVR     = 1;
    localparam int SERR_UND     = 0;
    localparam int SERR_W       = 2;

    typedef struct packed {
        logic push;
        logic pop;
        logic full;
        logic empty;
    } fifo_evt_t;

    function automatic logic is_fifo_mode(input logic [1:0] m);
        return m == DIR_MODE_FIFO;
    endfunction

endpackage

// File: rtl/w1c_flag_reg.sv
module w1c_flag_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_we,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_eff;

    always_comb clr_eff = clr_we ? clr : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_eff) | set;
    end

    // R8: a set bit is visible after the edge, even against a clear
    assert_set_sticks_R8: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((q & $past(set)) == $past(set)));

    // R8: cleared bits that were not set go low
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_we && ((clr & ~set) != '0)) |=> ((q & $past(clr & ~set)) == '0));
endmodule

// File: rtl/xfer_word_counter.sv
module xfer_word_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] fifo_lim,
    input  logic [CNT_W-1:0] blk_lim,
    input  logic             evt,
    output logic             hit
);
    import xfer_status_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [CNT_W:0]   nxt;

    always_comb begin
        lim = is_fifo_mode(mode) ? fifo_lim : blk_lim;
        nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
        hit = run && evt && (lim != '0) && (nxt == {1'b0, lim});
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (evt)    cnt <= nxt[CNT_W-1:0];
    end

    assert_idle_count_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    assert_hit_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
        hit |-> run);

    assert_zero_limit_never_done_R3: assert property (@(posedge clk) disable iff (rst)
        (lim == '0) |-> !hit);
endmodule

// File: rtl/xfer_status_unit.sv
module xfer_status_unit #(
    parameter int CNT_W       = 16,
    parameter int FIFO_DEPTH  = 64,
    parameter int BLOCK_WORDS = 16,
    parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [1:0]       in_mode,
    input  logic [1:0]       out_mode,
    input  logic [CNT_W-1:0] rd_cnt,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [CNT_W-1:0] in_cnt,
    input  logic [CNT_W-1:0] out_cnt,
    input  logic             in_push,
    input  logic             in_pop,
    input  logic             in_full,
    input  logic             in_empty,
    input  logic [LVL_W-1:0] in_level,
    input  logic             out_push,
    input  logic             out_pop,
    input  logic             out_full,
    input  logic             out_empty,
    input  logic [LVL_W-1:0] out_level,
    input  logic             sclk_ovr_evt,
    input  logic             sclk_und_evt,
    input  logic [5:0]       err_en,
    input  logic [1:0]       serr_en,
    input  logic             op_clr_we,
    input  logic [11:0]      op_clr,
    input  logic             err_clr_we,
    input  logic [5:0]       err_clr,
    input  logic             serr_clr_we,
    input  logic [1:0]       serr_clr,
    output logic [11:0]      op_flags,
    output logic [5:0]       err_flags,
    output logic [1:0]       serr_flags,
    output logic             irq
);
    import xfer_status_pkg::*;

    localparam logic [LVL_W:0] DEPTH_L = (LVL_W+1)'(FIFO_DEPTH);
    localparam logic [LVL_W:0] BLK_L   = (LVL_W+1)'(BLOCK_WORDS);

    fifo_evt_t ife, ofe;
    logic      in_hit, out_hit;
    logic      in_srv, out_srv;
    logic [LVL_W:0] out_room;
    logic [3:0]        op_set, op_q;
    logic [ERR_W-1:0]  err_set;
    logic [SERR_W-1:0] serr_set;

    always_comb begin
        ife = '{push: in_push,  pop: in_pop,  full: in_full,  empty: in_empty};
        ofe = '{push: out_push, pop: out_pop, full: out_full, empty: out_empty};
    end

    xfer_word_counter #(.CNT_W(CNT_W)) u_in_cnt (
        .clk(clk), .rst(rst), .run(run), .mode(in_mode),
        .fifo_lim(rd_cnt), .blk_lim(in_cnt),
        .evt(ife.push && !ife.full), .hit(in_hit)
    );

    xfer_word_counter #(.CNT_W(CNT_W)) u_out_cnt (
        .clk(clk), .rst(rst), .run(run), .mode(out_mode),
        .fifo_lim(wr_cnt), .blk_lim(out_cnt),
        .evt(ofe.pop && !ofe.empty), .hit(out_hit)
    );

    // service requests
    always_comb begin
        out_room = DEPTH_L - {1'b0, out_level};
        in_srv   = run && (is_fifo_mode(in_mode) ? !ife.empty
                                                 : ({1'b0, in_level} >= BLK_L));
        out_srv  = run && (is_fifo_mode(out_mode) ? !ofe.full
                                                  : (out_room >= BLK_L));
        op_set   = {in_hit, out_hit, in_srv, out_srv};
    end

    // FIFO and serial errors
    always_comb begin
        err_set              = '0;
        err_set[ERR_IN_OVR]  = ife.push && ife.full;
        err_set[ERR_IN_UND]  = ife.pop  && ife.empty;
        err_set[ERR_OUT_OVR] = ofe.push && ofe.full;
        err_set[ERR_OUT_UND] = ofe.pop  && ofe.empty && run;
        serr_set             = '0;
        serr_set[SERR_OVR]   = sclk_ovr_evt;
        serr_set[SERR_UND]   = sclk_und_evt;
    end

    w1c_flag_reg #(.W(4)) u_op_reg (
        .clk(clk), .rst(rst), .set(op_set),
        .clr_we(op_clr_we), .clr(op_clr[OP_IN_DONE:OP_OUT_SRV]), .q(op_q)
    );

    w1c_flag_reg #(.W(ERR_W)) u_err_reg (
        .clk(clk), .rst(rst), .set(err_set),
        .clr_we(err_clr_we), .clr(err_clr), .q(err_flags)
    );

    w1c_flag_reg #(.W(SERR_W)) u_serr_reg (
        .clk(clk), .rst(rst), .set(serr_set),
        .clr_we(serr_clr_we), .clr(serr_clr), .q(serr_flags)
    );

    always_comb begin
        op_flags = {op_q, ife.full, ofe.full, !ife.empty, !ofe.empty, 4'b0000};
        irq      = (|op_q) || (|(err_flags & err_en)) || (|(serr_flags & serr_en));
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (op_q == '0 && err_flags == '0 && serr_flags == '0));

    assert_in_overrun_R6: assert property (@(posedge clk) disable iff (rst)
        (in_push && in_full) |=> err_flags[ERR_IN_OVR]);

    assert_out_underrun_R6: assert property (@(posedge clk) disable iff (rst)
        (out_pop && out_empty && run) |=> err_flags[ERR_OUT_UND]);

    assert_clk_fault_R7: assert property (@(posedge clk) disable iff (rst)
        sclk_ovr_evt |=> serr_flags[SERR_OVR]);

    assert_irq_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !op_clr_we && !err_clr_we && !serr_clr_we
         && $stable(err_en) && $stable(serr_en)) |=> irq);

    assert_input_done_R3: assert property (@(posedge clk) disable iff (rst)
        in_hit |=> op_flags[OP_IN_DONE]);
endmodule

// File: tb/xfer_status_unit_tb.sv
module xfer_status_unit_tb;
    localparam int CNT_W = 8;
    localparam int DEPTH = 8;
    localparam int BLK   = 4;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst;
    logic run;
    logic [1:0] in_mode, out_mode;
    logic [CNT_W-1:0] rd_cnt, wr_cnt, in_cnt, out_cnt;
    logic in_push, in_pop, in_full, in_empty;
    logic out_push, out_pop, out_full, out_empty;
    logic [LVL_W-1:0] in_level, out_level;
    logic sclk_ovr_evt, sclk_und_evt;
    logic [5:0] err_en;
    logic [1:0] serr_en;
    logic op_clr_we, err_clr_we, serr_clr_we;
    logic [11:0] op_clr;
    logic [5:0] err_clr;
    logic [1:0] serr_clr;
    logic [11:0] op_flags;
    logic [5:0] err_flags;
    logic [1:0] serr_flags;
    logic irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xfer_status_unit #(.CNT_W(CNT_W), .FIFO_DEPTH(DEPTH), .BLOCK_WORDS(BLK)) u_dut (
        .clk(clk), .rst(rst), .run(run), .in_mode(in_mode), .out_mode(out_mode),
        .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .in_cnt(in_cnt), .out_cnt(out_cnt),
        .in_push(in_push), .in_pop(in_pop), .in_full(in_full), .in_empty(in_empty),
        .in_level(in_level), .out_push(out_push), .out_pop(out_pop),
        .out_full(out_full), .out_empty(out_empty), .out_level(out_level),
        .sclk_ovr_evt(sclk_ovr_evt), .sclk_und_evt(sclk_und_evt),
        .err_en(err_en), .serr_en(serr_en),
        .op_clr_we(op_clr_we), .op_clr(op_clr), .err_clr_we(err_clr_we),
        .err_clr(err_clr), .serr_clr_we(serr_clr_we), .serr_clr(serr_clr),
        .op_flags(op_flags), .err_flags(err_flags), .serr_flags(serr_flags), .irq(irq)
    );

    // {in_push,in_pop,in_full,in_empty,out_push,out_pop,out_full,out_empty,run, expected err[5:0]}
    localparam logic [14:0] VEC [8] = '{
        15'b1010_0001_0_000100,
        15'b0101_0001_0_010000,
        15'b0001_1010_0_100000,
        15'b0001_0101_1_001000,
        15'b0001_0101_0_000000,
        15'b1100_0001_0_000000,
        15'b1111_1111_1_111100,
        15'b1001_0100_1_000000
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        run = 0; in_push = 0; in_pop = 0; in_full = 0; in_empty = 1;
        out_push = 0; out_pop = 0; out_full = 0; out_empty = 1;
        in_level = '0; out_level = '0;
        sclk_ovr_evt = 0; sclk_und_evt = 0;
        op_clr_we = 0; err_clr_we = 0; serr_clr_we = 0;
        op_clr = '0; err_clr = '0; serr_clr = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        idle();
        step();
        op_clr_we = 1; op_clr = 12'hFFF;
        err_clr_we = 1; err_clr = 6'h3F;
        serr_clr_we = 1; serr_clr = 2'h3;
        step();
        idle();
    endtask

    initial begin
        rst = 1; idle();
        in_mode = 2'd0; out_mode = 2'd0;
        rd_cnt = '0; wr_cnt = '0; in_cnt = '0; out_cnt = '0;
        err_en = '0; serr_en = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        step();

        // R1 reset state
        chk("R1", "op_flags after reset", 32'(op_flags), 32'h000);
        chk("R1", "err_flags after reset", 32'(err_flags), 32'h00);
        chk("R1", "serr_flags after reset", 32'(serr_flags), 32'h0);
        chk("R1", "irq after reset", 32'(irq), 32'h0);

        // R2 live status bits
        in_full = 1; in_empty = 0; out_empty = 0;
        #1;
        chk("R2", "live status bits", 32'(op_flags[7:4]), 32'hB);
        op_clr_we = 1; op_clr = 12'h0F0;
        step();
        op_clr_we = 0;
        chk("R2", "live bits after clear write", 32'(op_flags[7:4]), 32'hB);
        idle();
        step();

        // R6 / R10 error vectors
        for (int i = 0; i < 8; i++) begin
            {in_push, in_pop, in_full, in_empty, out_push, out_pop, out_full, out_empty, run}
                = VEC[i][14:6];
            step();
            idle();
            chk(i == 4 ? "R10" : "R6", $sformatf("err vector %0d", i),
                32'(err_flags), 32'(VEC[i][5:0]));
            clear_all();
        end
        chk("R8", "all flags cleared after vectors", 32'(err_flags), 32'h0);

        // R8 partial clear and set-wins
        in_push = 1; in_full = 1; out_push = 1; out_full = 1;
        step();
        idle();
        chk("R6", "two overruns", 32'(err_flags), 32'h24);
        err_clr_we = 1; err_clr = 6'b000100;
        step();
        idle();
        chk("R8", "partial clear keeps bit5", 32'(err_flags), 32'h20);
        in_push = 1; in_full = 1; err_clr_we = 1; err_clr = 6'b000100;
        step();
        idle();
        chk("R8", "set wins over clear", 32'(err_flags), 32'h24);
        clear_all();

        // R9 enables
        in_push = 1; in_full = 1;
        step();
        idle();
        chk("R9", "disabled error recorded", 32'(err_flags[2]), 32'h1);
        chk("R9", "disabled error no irq", 32'(irq), 32'h0);
        err_en = 6'b000100;
        step();
        chk("R9", "enabled error irq", 32'(irq), 32'h1);
        step();
        chk("R9", "irq held", 32'(irq), 32'h1);
        err_clr_we = 1; err_clr = 6'b000100;
        step();
        idle();
        chk("R9", "irq drops after clear", 32'(irq), 32'h0);
        err_en = '0;

        // R7 serial clock errors
        sclk_ovr_evt = 1;
        step();
        idle();
        chk("R7", "clock overrun flag", 32'(serr_flags), 32'h2);
        chk("R9", "serial error disabled no irq", 32'(irq), 32'h0);
        serr_en = 2'b10;
        #1;
        chk("R9", "serial error enabled irq", 32'(irq), 32'h1);
        sclk_und_evt = 1;
        step();
        idle();
        chk("R7", "clock underrun flag", 32'(serr_flags), 32'h3);
        clear_all();
        serr_en = '0;
        chk("R7", "serial flags cleared", 32'(serr_flags), 32'h0);

        // R3 input done, FIFO mode uses rd_cnt
        in_mode = 2'd0; rd_cnt = 8'd3; in_cnt = 8'd5;
        run = 1; in_empty = 0; in_push = 1;
        step();
        chk("R3", "fifo input one word", 32'(op_flags[11]), 32'h0);
        step();
        chk("R3", "fifo input two words", 32'(op_flags[11]), 32'h0);
        step();
        chk("R3", "fifo input done at rd_cnt", 32'(op_flags[11]), 32'h1);
        chk("R4", "fifo mode input service", 32'(op_flags[9]), 32'h1);
        chk("R9", "irq from op flags", 32'(irq), 32'h1);
        clear_all();
        chk("R8", "op flags cleared", 32'(op_flags[11:8]), 32'h0);

        // R3 input done, block mode uses in_cnt
        in_mode = 2'd1; in_cnt = 8'd2; rd_cnt = 8'd7;
        run = 1; in_empty = 0; in_push = 1;
        step();
        chk("R3", "block input one word", 32'(op_flags[11]), 32'h0);
        step();
        chk("R3", "block input done at in_cnt", 32'(op_flags[11]), 32'h1);
        chk("R4", "block mode below block no service", 32'(op_flags[9]), 32'h0);
        clear_all();

        // R3 output done and zero limit
        out_mode = 2'd0; wr_cnt = 8'd1; out_cnt = 8'd3;
        run = 1; out_pop = 1; out_empty = 0; out_full = 1;
        step();
        chk("R3", "fifo output done at wr_cnt", 32'(op_flags[10]), 32'h1);
        clear_all();
        wr_cnt = 8'd0;
        run = 1; out_pop = 1; out_empty = 0; out_full = 1;
        repeat (3) step();
        chk("R3", "zero limit never done", 32'(op_flags[10]), 32'h0);
        clear_all();

        // R4 block-mode input service threshold
        in_mode = 2'd1; out_mode = 2'd1; out_full = 1; out_level = LVL_W'(DEPTH);
        run = 1; in_empty = 0; in_level = LVL_W'(BLK - 1);
        step();
        chk("R4", "level below block", 32'(op_flags[9]), 32'h0);
        in_level = LVL_W'(BLK);
        step();
        chk("R4", "level reaches block", 32'(op_flags[9]), 32'h1);
        chk("R5", "block mode no room no service", 32'(op_flags[8]), 32'h0);
        clear_all();

        // R5 block-mode output room threshold
        out_mode = 2'd1; run = 1; out_level = LVL_W'(DEPTH - BLK + 1);
        step();
        chk("R5", "room below block", 32'(op_flags[8]), 32'h0);
        out_level = LVL_W'(DEPTH - BLK);
        step();
        chk("R5", "room reaches block", 32'(op_flags[8]), 32'h1);
        clear_all();
        out_mode = 2'd0; run = 1; out_full = 0; out_level = LVL_W'(DEPTH - 1);
        step();
        chk("R5", "fifo mode not full service", 32'(op_flags[8]), 32'h1);
        clear_all();
        chk("R9", "irq low when all clear", 32'(irq), 32'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule